// File: doc/BRIEF.md
# Pipelined Wide Word Multiplexer

This block picks one word out of a large flat vector of equally sized words and delivers it on a single output word. The selection is done by a tree of small K-to-1 selection stages. Each stage handles a slice of the binary selector and reduces the word count by a factor of K. Pipeline registers can be placed after every D stages, so the designer controls how many levels of selection logic sit between two flops.

The selector enters with the data and is consumed a slice at a time. Its unconsumed high bits are delayed through the same pipeline banks as the partial results, so a new selection can be presented every clock cycle. When a word count is not a multiple of K, the missing lanes are filled with zero words. The selector is also zero-extended at the top so that it splits into whole per-stage slices. Optional flops on the inputs and on the output add one cycle each. The latency is therefore fixed by the parameters alone.

K must be a power of two and at least 2, N at least 2, and D at least 1. Elaboration stops with an error otherwise.

Top module: `pmux_tree`

## Requirements
- R1: With a selector value s below N_WORDS, the output is the word held in bits [s*DW +: DW] of the data input. Word 0 sits in the least significant bits.
- R2: A selector value of N_WORDS or more, which addresses a zero-padded lane, yields an all-zero output word.
- R3: The latency in clock cycles is IN_REG plus the number of stage banks plus OUT_REG.
  - A bank follows stage number s, counted from 1, when s is a multiple of DEPTH and that stage leaves more than one word.
  - With N_WORDS=13, K=8, DEPTH=1 and both optional registers enabled, the latency is 3.
  - With N_WORDS=37, K=2, DEPTH=2 and no optional registers, the latency is 2.
- R4: A new selector and data vector may be applied on every cycle. Each result depends only on the inputs of its own cycle, including when the selector has been zero-extended to whole per-stage slices.
- R5: Reset is synchronous and active low. Every register loads zero at a rising edge while rst_n is 0, so the output reads zero after such an edge, whatever the inputs are.
- R6: The remaining selector bits are captured in the same banks as the partial words.
  - A change of the selector alone reaches the output after exactly the same latency as a change of the data alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | N_WORDS*DW | Packed input words, word 0 in the least significant bits |
| sel_in | input | ceil(log2(N_WORDS)) | Binary index of the word to pass |
| data_out | output | DW | Selected word, delayed by the pipeline latency |

## Verification
The bench builds two instances of the block.

The first uses 13 words of 8 bits with K=8, DEPTH=1 and both optional registers. Its single lane group of the second stage is mostly padding, its 4-bit selector is widened to 6 bits, and selector values 13 to 15 fall into padded lanes.

The second uses 37 words with K=2, DEPTH=2 and no optional registers. It has six stages with odd word counts at several levels, and the bank rule places banks after stages 2 and 4 but not after stage 6.

Between them the two instances cover both settings of each optional register and two different latencies. They also cover padding both inside the data groups and on the selector.

// File: rtl/pmux_pkg.sv
// Package: constant helpers shared by the multiplexer tree.
// Assumes: all arguments are positive elaboration-time integers.
package pmux_pkg;

    // Smallest r with 2**r >= v (at least 1 for v >= 2).
    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // Integer division rounded up.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Word count entering stage s (s = 0 is the first stage).
    function automatic int words_at(input int n, input int k, input int s);
        int w;
        w = n;
        for (int i = 0; i < s; i++) w = ceil_div(w, k);
        return w;
    endfunction

    // Number of K-to-1 stages needed to reach a single word.
    function automatic int stage_count(input int n, input int k);
        int w;
        int c;
        w = n;
        c = 0;
        while (w > 1) begin
            w = ceil_div(w, k);
            c++;
        end
        return c;
    endfunction

    // True when a register bank follows zero-based stage s.
    function automatic bit bank_after(input int n, input int k, input int d, input int s);
        return (((s + 1) % d) == 0) && (words_at(n, k, s + 1) > 1);
    endfunction

    // True for powers of two of at least 2.
    function automatic bit is_pow2(input int v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pmux_leaf.sv
// Module: pmux_leaf
// Passes one of K lanes of DW bits, chosen by a binary pick index.
// Built as a decoded AND-OR so that depth grows with log2(K) only.
// Assumes: K is a power of two, so every pick value names a lane.
module pmux_leaf #(
    parameter int K  = 4,
    parameter int DW = 8,
    localparam int PW = pmux_pkg::ceil_log2(K)
) (
    input  logic [K*DW-1:0] lanes,
    input  logic [PW-1:0]   pick,
    output logic [DW-1:0]   word
);

    logic [K-1:0]         hit;
    logic [K-1:0][DW-1:0] masked;

    // Decode the pick index and gate each lane by its hit bit.
    for (genvar g = 0; g < K; g++) begin : g_lane
        assign hit[g]    = (pick == PW'(g));
        assign masked[g] = lanes[g*DW +: DW] & {DW{hit[g]}};
    end

    // Merge the gated lanes into one word.
    always_comb begin
        word = '0;
        for (int i = 0; i < K; i++) word = word | masked[i];
    end

    // At most one lane may be enabled at a time (R1).
    always_comb begin
        assert_lane_onehot_R1: assert ($onehot0(hit));
    end

endmodule

// File: rtl/pmux_stage.sv
// Module: pmux_stage
// One level of the tree. It zero-pads W_IN words up to a multiple of K and
// reduces each group of K words to one word, using the low selector slice.
// It forwards the high selector bits. With BANK set, both the words and the
// forwarded selector bits pass through one register bank.
// Assumes: SI_W >= log2(K). When SI_W equals log2(K), sel_out is a one-bit
// zero placeholder.
module pmux_stage #(
    parameter int DW   = 8,
    parameter int K    = 4,
    parameter int W_IN = 13,
    parameter int SI_W = 4,
    parameter bit BANK = 1'b1,
    localparam int PW    = pmux_pkg::ceil_log2(K),
    localparam int W_OUT = pmux_pkg::ceil_div(W_IN, K),
    localparam int SO_W  = (SI_W > PW) ? (SI_W - PW) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W_IN*DW-1:0]  din,
    input  logic [SI_W-1:0]     sel_in,
    output logic [W_OUT*DW-1:0] dout,
    output logic [SO_W-1:0]     sel_out
);

    localparam int W_PAD     = W_OUT * K;
    localparam int PAD       = W_PAD - W_IN;
    localparam int LAST_REAL = W_IN - (W_OUT - 1) * K;

    logic [W_PAD*DW-1:0] din_pad;
    logic [PW-1:0]       pick;
    logic [SO_W-1:0]     sel_hi;
    logic [W_OUT*DW-1:0] dcomb;

    // Extend the input with zero words at the high end.
    if (PAD > 0) begin : g_pad
        assign din_pad = {{(PAD*DW){1'b0}}, din};
    end else begin : g_nopad
        assign din_pad = din;
    end

    // Split the selector into this stage's slice and the remainder.
    assign pick = sel_in[PW-1:0];
    if (SI_W > PW) begin : g_selhi
        assign sel_hi = sel_in[SI_W-1:PW];
    end else begin : g_selend
        assign sel_hi = '0;
    end

    // One K-to-1 selector per group of K words.
    for (genvar g = 0; g < W_OUT; g++) begin : g_grp
        pmux_leaf #(.K(K), .DW(DW)) u_leaf (
            .lanes (din_pad[g*K*DW +: K*DW]),
            .pick  (pick),
            .word  (dcomb[g*DW +: DW])
        );
    end

    if (BANK) begin : g_bank
        logic [W_OUT*DW-1:0] dq;
        logic [SO_W-1:0]     sq;

        // Register the partial words together with the unused selector bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dq <= '0;
                sq <= '0;
            end else begin
                dq <= dcomb;
                sq <= sel_hi;
            end
        end
        assign dout    = dq;
        assign sel_out = sq;

        // Words and selector remainder advance in the same cycle (R6).
        assert_bank_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (dout == $past(dcomb)) && (sel_out == $past(sel_hi)));
    end else begin : g_wire
        assign dout    = dcomb;
        assign sel_out = sel_hi;
    end

    if (LAST_REAL < K) begin : g_padchk
        // A pick that lands on a padded lane of the last group gives zero (R2).
        assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pick >= PW'(LAST_REAL)) |-> (dcomb[(W_OUT-1)*DW +: DW] == '0));
    end

endmodule

// File: rtl/pmux_tree.sv
// Module: pmux_tree (top)
// N_WORDS-to-1 word selector built from K-to-1 stages, with a register bank
// after every DEPTH stages and optional input and output flops.
// Assumes: K is a power of two, K >= 2, N_WORDS >= 2 and DEPTH >= 1.
module pmux_tree #(
    parameter int N_WORDS = 32,
    parameter int DW      = 8,
    parameter int K       = 4,
    parameter int DEPTH   = 1,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1,
    localparam int SEL_W  = pmux_pkg::ceil_log2(N_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_WORDS*DW-1:0] data_in,
    input  logic [SEL_W-1:0]      sel_in,
    output logic [DW-1:0]         data_out
);

    localparam int PW     = pmux_pkg::ceil_log2(K);
    localparam int NSTG   = pmux_pkg::stage_count(N_WORDS, K);
    localparam int SELP_W = NSTG * PW;

    if (!pmux_pkg::is_pow2(K) || (N_WORDS < 2) || (DEPTH < 1)) begin : g_badcfg
        $error("pmux_tree: unsupported K, N_WORDS or DEPTH");
    end

    logic [N_WORDS*DW-1:0] data_q;
    logic [SEL_W-1:0]      sel_q;
    logic [SELP_W-1:0]     sel_p;
    logic [DW-1:0]         tree_out;

    if (IN_REG) begin : g_inreg
        logic [N_WORDS*DW-1:0] dq;
        logic [SEL_W-1:0]      sq;
        // Capture the data vector and the selector at the block edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dq <= '0;
                sq <= '0;
            end else begin
                dq <= data_in;
                sq <= sel_in;
            end
        end
        assign data_q = dq;
        assign sel_q  = sq;
    end else begin : g_inwire
        assign data_q = data_in;
        assign sel_q  = sel_in;
    end

    // Zero-extend the selector to a whole number of per-stage slices.
    if (SELP_W > SEL_W) begin : g_selpad
        assign sel_p = {{(SELP_W-SEL_W){1'b0}}, sel_q};
    end else begin : g_selfit
        assign sel_p = sel_q;
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam int WI = pmux_pkg::words_at(N_WORDS, K, s);
        localparam int WO = pmux_pkg::ceil_div(WI, K);
        localparam int SI = SELP_W - s * PW;
        localparam int SO = (SI > PW) ? (SI - PW) : 1;

        logic [WI*DW-1:0] st_din;
        logic [SI-1:0]    st_sel;
        logic [WO*DW-1:0] st_dout;
        logic [SO-1:0]    st_selo;

        // Feed the stage from the block input or from the previous stage.
        if (s == 0) begin : g_first
            assign st_din = data_q;
            assign st_sel = sel_p;
        end else begin : g_next
            assign st_din = g_stage[s-1].st_dout;
            assign st_sel = g_stage[s-1].st_selo;
        end

        pmux_stage #(
            .DW   (DW),
            .K    (K),
            .W_IN (WI),
            .SI_W (SI),
            .BANK (pmux_pkg::bank_after(N_WORDS, K, DEPTH, s))
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (st_din),
            .sel_in  (st_sel),
            .dout    (st_dout),
            .sel_out (st_selo)
        );
    end

    assign tree_out = g_stage[NSTG-1].st_dout;

    if (OUT_REG) begin : g_outreg
        logic [DW-1:0] oq;
        // Hold the selected word for one cycle at the block edge.
        always_ff @(posedge clk) begin
            if (!rst_n) oq <= '0;
            else        oq <= tree_out;
        end
        assign data_out = oq;

        // An edge with reset low leaves a zero output (R5).
        assert_reset_clear_R5: assert property (@(posedge clk)
            !rst_n |=> (data_out == '0));
    end else begin : g_outwire
        assign data_out = tree_out;
    end

endmodule

// File: tb/pmux_tree_tb_top.sv
// Bench: two configurations checked against a model of the requirements.
module pmux_tree_tb_top;

    localparam int NA = 13;
    localparam int KA = 8;
    localparam int DA = 1;
    localparam int NB = 37;
    localparam int KB = 2;
    localparam int DB = 2;
    localparam int DWB = 8;

    // Latency from R3: input flag + banks + output flag.
    function automatic int exp_lat(input int n, input int k, input int d, input int ir, input int orr);
        int w;
        int b;
        int s;
        w = n;
        b = 0;
        s = 1;
        while (w > 1) begin
            w = (w + k - 1) / k;
            if ((s % d == 0) && (w > 1)) b++;
            s++;
        end
        return ir + b + orr;
    endfunction

    localparam int LAT_A = exp_lat(NA, KA, DA, 1, 1);
    localparam int LAT_B = exp_lat(NB, KB, DB, 0, 0);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NA*DWB-1:0] dA = '0;
    logic [3:0]        sA = '0;
    logic [NB*DWB-1:0] dB = '0;
    logic [5:0]        sB = '0;
    logic [DWB-1:0]    oA;
    logic [DWB-1:0]    oB;

    int total = 0;
    int bad = 0;
    int pushes = 0;

    logic [7:0] hA [0:3];
    logic [7:0] hB [0:3];
    string      tg [0:3];

    always #2.5 clk = ~clk;

    pmux_tree #(.N_WORDS(NA), .DW(DWB), .K(KA), .DEPTH(DA), .IN_REG(1'b1), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .data_in(dA), .sel_in(sA), .data_out(oA));

    pmux_tree #(.N_WORDS(NB), .DW(DWB), .K(KB), .DEPTH(DB), .IN_REG(1'b0), .OUT_REG(1'b0)) dut2_i (
        .clk(clk), .rst_n(rst_n), .data_in(dB), .sel_in(sB), .data_out(oB));

    // Expected word per R1 and R2.
    function automatic logic [7:0] pick_word(input logic [NB*DWB-1:0] d, input int s, input int n);
        if (s >= n) return 8'h00;
        return d[s*8 +: 8];
    endfunction

    task automatic chk(input string tag, input string who, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    task automatic rand_data();
        for (int i = 0; i < NA; i++) dA[i*8 +: 8] = 8'($urandom);
        for (int i = 0; i < NB; i++) dB[i*8 +: 8] = 8'($urandom);
    endtask

    // mode: 0 random, 1 first word, 2 last word, 3 padded lane,
    //       4 selector change only, 5 data change only
    task automatic step(input int mode, input string tag);
        @(negedge clk);
        case (mode)
            0: begin rand_data(); sA = 4'($urandom % NA); sB = 6'($urandom % NB); end
            1: begin rand_data(); sA = 4'd0; sB = 6'd0; end
            2: begin rand_data(); sA = 4'(NA - 1); sB = 6'(NB - 1); end
            3: begin rand_data(); sA = 4'(NA + $urandom % (16 - NA)); sB = 6'(NB + $urandom % (64 - NB)); end
            4: begin sA = 4'($urandom % NA); sB = 6'($urandom % NB); end
            default: rand_data();
        endcase
        for (int i = 3; i > 0; i--) begin
            hA[i] = hA[i-1];
            hB[i] = hB[i-1];
            tg[i] = tg[i-1];
        end
        hA[0] = pick_word({{((NB-NA)*DWB){1'b0}}, dA}, int'(sA), NA);
        hB[0] = pick_word(dB, int'(sB), NB);
        tg[0] = tag;
        pushes++;
        #1;
        if (pushes > LAT_A) chk(tg[LAT_A], "cfgA", oA, hA[LAT_A]);
        if (pushes > LAT_B) chk(tg[LAT_B], "cfgB", oB, hB[LAT_B]);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            hA[i] = '0;
            hB[i] = '0;
            tg[i] = "";
        end
        // R3: the latencies derived for the two configurations.
        total++;
        if (LAT_A != 3 || LAT_B != 2) begin
            bad++;
            $display("FAIL R3 latency actual=%0d/%0d expected=3/2", LAT_A, LAT_B);
        end
        // R5: the output is zero after edges with reset low, despite busy inputs.
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            rand_data();
            sA = 4'd5;
            sB = 6'd9;
            #1;
            chk("R5", "cfgA", oA, 8'h00);
            chk("R5", "cfgB", oB, 8'h00);
        end
        @(negedge clk);
        rst_n = 1'b1;
        pushes = 0;
        for (int i = 0; i < 4; i++) step(1, "R1_first");
        for (int i = 0; i < 4; i++) step(2, "R1_last");
        for (int i = 0; i < 8; i++) step(3, "R2");
        for (int i = 0; i < 8; i++) step(5, "R3_dataonly");
        for (int i = 0; i < 8; i++) step(4, "R6_selonly");
        for (int i = 0; i < 6; i++) step(5, "R6_dataonly");
        for (int i = 0; i < 2000; i++) begin
            int m;
            m = int'($urandom % 10);
            if (m < 6)       step(0, "R4");
            else if (m == 6) step(3, "R2");
            else if (m == 7) step(4, "R6");
            else if (m == 8) step(5, "R3");
            else             step(2, "R1");
        end
        for (int i = 0; i < 4; i++) step(0, "R4_flush");
        // R5: a reset in mid-run clears the registered output.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R5_midrun", "cfgA", oA, 8'h00);
        chk("R5_midrun", "cfgB", oB, 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule